// File: doc/BRIEF.md
# Polled-Link Slave Byte Buffer

This block sits at the remote end of a polled parallel link. A master visits each station in turn for one addressing slot. The first half of a slot is a low-byte phase and the second half is a high-byte phase. When the bus carries this station's address, the block stores the master's byte for the current phase in a buffer register. It also drives one byte of local reply data back onto the bus. Toward the local controller the block looks like a plain 16-bit input word, assembled from the two received bytes, and a 16-bit output word, which is split into the two reply bytes.

An optional interrupt lets the local controller react within a single slot. The interrupt is raised as soon as a low-byte phase for this station begins. The controller reads the fresh low byte and updates its output word. The high reply byte is taken from that output word only at the change from the low phase to the high phase, so the master receives the response in the high half of the same slot. A configuration input turns the interrupt on or off. The station address is a configuration input as well.

Top module: `slave_byte_buffer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `loc_in` is 0 and `irq` is 0. While unselected, `bus_rdata` is 0 and `bus_rdata_vld` is 0.
- R2: The station is selected when `bus_valid` is 1 and `bus_addr` equals `station_addr`. In every selected cycle with `bus_phase`=0 (low phase), `bus_wdata` is stored and appears on `loc_in[7:0]` one cycle later. The value from the last such cycle is held afterwards.
- R3: In every selected cycle with `bus_phase`=1 (high phase), `bus_wdata` is stored and appears on `loc_in[15:8]` one cycle later.
- R4: When the station is not selected, `loc_in` does not change, `bus_rdata` is 0 and `bus_rdata_vld` is 0.
- R5: A phase start is a selected cycle whose previous cycle was unselected or was in the other phase. With `irq_en`=1, a low-phase start sets `irq` to 1 in the next cycle.
- R6: With `irq_en`=0, `irq` is 0 in the following cycle, and no interrupt is produced.
- R7: Once set, `irq` stays at 1 until `irq_ack` is 1 for a cycle. `irq` is then 0 in the next cycle, unless a low-phase start occurs in that same cycle, in which case `irq` stays at 1.
- R8: At each low-phase start, `loc_out[7:0]` is captured. While the station is selected in the low phase, `bus_rdata` shows the captured value.
- R9: At each high-phase start, which includes the low-to-high change, `loc_out[15:8]` is captured. While the station is selected in the high phase, `bus_rdata` shows the captured value. Later changes to `loc_out` do not alter it within that phase.
- R10: `bus_rdata_vld` is 1 exactly in selected cycles that are not phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Master is presenting an address |
| bus_addr | input | ADDR_W | Station address on the bus |
| bus_phase | input | 1 | 0 for the low-byte phase, 1 for the high-byte phase |
| bus_wdata | input | BYTE_W | Byte from the master |
| bus_rdata | output | BYTE_W | Reply byte to the master |
| bus_rdata_vld | output | 1 | Reply byte is settled |
| station_addr | input | ADDR_W | This station's configured address |
| irq_en | input | 1 | Interrupt enable configuration |
| loc_in | output | 2*BYTE_W | Received word toward the local controller |
| loc_out | input | 2*BYTE_W | Local controller's output word |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |

## Verification
The bench runs several kinds of slot:
- A full low-then-high slot at this station's address, with the data byte changing inside each phase. This separates last-write-wins storage from first-cycle capture.
- Slots at another address, and slots with `bus_valid` low. These show that foreign traffic leaves every output untouched.
- Slots that start directly in the high phase, and slots placed back to back. These test how phase starts are detected.
- Changes to `loc_out` in the middle of a phase, which show whether the reply byte is frozen.
- Acknowledges placed before, during and after a new low-phase start, with `irq_en` toggled. These separate the set, hold and clear priorities of the interrupt.

// File: rtl/slave_byte_buffer.sv
module slave_byte_buffer #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_phase,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_rdata_vld,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              irq_en,
  output logic [WORD_W-1:0] loc_in,
  input  logic [WORD_W-1:0] loc_out,
  output logic              irq,
  input  logic              irq_ack
);

  logic              sel, sel_q, phase_q;
  logic              phase_start, lo_start, hi_start;
  logic [BYTE_W-1:0] rx_lo, rx_hi, rep_lo, rep_hi;

  assign sel         = bus_valid && (bus_addr == station_addr);
  assign phase_start = sel && !(sel_q && (phase_q == bus_phase));
  assign lo_start    = phase_start && !bus_phase;
  assign hi_start    = phase_start && bus_phase;

  assign loc_in        = {rx_hi, rx_lo};
  assign bus_rdata     = !sel ? '0 : (bus_phase ? rep_hi : rep_lo);
  assign bus_rdata_vld = sel && !phase_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      sel_q   <= sel;
      phase_q <= bus_phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_lo <= '0;
      rx_hi <= '0;
    end else if (sel) begin
      if (bus_phase) rx_hi <= bus_wdata;
      else           rx_lo <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_lo <= '0;
      rep_hi <= '0;
    end else begin
      if (lo_start) rep_lo <= loc_out[BYTE_W-1:0];
      if (hi_start) rep_hi <= loc_out[WORD_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_en && (lo_start || (irq && !irq_ack));
  end

  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(loc_in));

  p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_start && irq_en) |=> irq);

  p_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);

  p_irq_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack && !lo_start) |=> !irq);

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack && irq_en) |=> irq);

  p_reply_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && bus_phase && bus_rdata_vld) |=> (!(sel && bus_phase) || $stable(bus_rdata)));

  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!bus_rdata_vld && bus_rdata == '0));

endmodule

// File: tb/slave_byte_buffer_bench.sv
module slave_byte_buffer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_phase = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [3:0] station_addr = 4'd5;
  logic       irq_en = 1'b1;
  logic [15:0] loc_out = '0;
  logic       irq_ack = 1'b0;
  logic [7:0] bus_rdata;
  logic       bus_rdata_vld;
  logic [15:0] loc_in;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  slave_byte_buffer u_slave_byte_buffer (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_phase(bus_phase), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_vld(bus_rdata_vld), .station_addr(station_addr), .irq_en(irq_en),
    .loc_in(loc_in), .loc_out(loc_out), .irq(irq), .irq_ack(irq_ack));

  // reference model state
  bit [7:0] m_lo, m_hi, m_rlo, m_rhi;
  bit       m_irq, m_psel, m_pph;

  function automatic bit m_sel();
    return bus_valid && (bus_addr == station_addr);
  endfunction

  function automatic bit m_start();
    return m_sel() && !(m_psel && (m_pph == bus_phase));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_rlo = 0; m_rhi = 0; m_irq = 0; m_psel = 0; m_pph = 0;
    end else begin
      bit s, st;
      s  = m_sel();
      st = m_start();
      if (st && !bus_phase) m_rlo = loc_out[7:0];
      if (st && bus_phase)  m_rhi = loc_out[15:8];
      m_irq = irq_en && ((st && !bus_phase) || (m_irq && !irq_ack));
      if (s && !bus_phase) m_lo = bus_wdata;
      if (s && bus_phase)  m_hi = bus_wdata;
      m_psel = s;
      m_pph  = bus_phase;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cycles++;
    if (!rst_n) begin
      chk("R1 loc_in", loc_in, 16'h0);
      chk("R1 irq", {15'h0, irq}, 16'h0);
    end else begin
      chk("R2/R3/R4 loc_in", loc_in, {m_hi, m_lo});
      chk("R5/R6/R7 irq", {15'h0, irq}, {15'h0, m_irq});
      chk("R8/R9/R4 bus_rdata", {8'h0, bus_rdata},
          {8'h0, m_sel() ? (bus_phase ? m_rhi : m_rlo) : 8'h00});
      chk("R10 bus_rdata_vld", {15'h0, bus_rdata_vld},
          {15'h0, m_sel() && !m_start()});
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(input bit v, input logic [3:0] a, input bit ph, input logic [7:0] wd);
    bus_valid = v; bus_addr = a; bus_phase = ph; bus_wdata = wd;
    tick();
  endtask

  task automatic slot(input logic [3:0] a, input int half, input logic [7:0] seed);
    for (int i = 0; i < half; i++) drive(1, a, 0, seed + 8'(i));
    loc_out = loc_out ^ 16'h5A00;
    for (int i = 0; i < half; i++) begin
      if (i == 2) loc_out = loc_out + 16'h1111;  // R9: mid-phase change must not show
      drive(1, a, 1, seed ^ 8'(8'hF0 + i));
    end
  endtask

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", {loc_in[15:1], irq}, 16'h0);
    // R2 R3 R5 R8 R9 R10: full slot for own address
    loc_out = 16'hA3C4;
    slot(4'd5, 6, 8'h10);
    drive(0, 4'd5, 0, 8'hEE);
    // R7: irq holds, then ack clears
    repeat (3) tick();
    irq_ack = 1; tick(); irq_ack = 0; tick();
    // R4: foreign address and idle bus
    slot(4'd3, 5, 8'h77);
    drive(0, 4'd5, 1, 8'h99);
    drive(0, 4'd5, 0, 8'h98);
    // R7: ack coincident with new low-phase start
    loc_out = 16'h0F0F;
    irq_ack = 1; drive(1, 4'd5, 0, 8'h21); irq_ack = 0;
    drive(1, 4'd5, 0, 8'h22);
    drive(1, 4'd5, 1, 8'h23);
    // R6: interrupts off
    irq_en = 0;
    slot(4'd5, 4, 8'h40);
    drive(0, 4'd0, 0, 8'h0);
    irq_en = 1;
    // slot starting in high phase, then back-to-back slots with address change
    drive(1, 4'd5, 1, 8'h61);
    drive(1, 4'd5, 1, 8'h62);
    slot(4'd5, 3, 8'h80);
    slot(4'd6, 3, 8'h90);
    slot(4'd5, 3, 8'hA0);
    // R5: fresh low start back to low after high
    drive(1, 4'd5, 0, 8'hB1);
    irq_ack = 1; drive(1, 4'd5, 0, 8'hB2); irq_ack = 0;
    drive(0, 4'd5, 0, 8'h00);
    // change station address, old address now foreign
    station_addr = 4'd9;
    slot(4'd5, 3, 8'hC0);
    slot(4'd9, 4, 8'hD0);
    drive(0, 4'd0, 0, 8'h00);
    tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule